// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block wraps a byte-wide static RAM in which every word has a shadow nonvolatile copy. In normal operation it behaves as a plain SRAM with a clocked chip-enable, output-enable and write-enable port. It also watches the stream of reads for a fixed series of six addresses. When the series arrives without interruption, the block starts a whole-array transfer. One final address selects a STORE, which copies the SRAM into the shadow array. The other final address selects a RECALL, which clears the SRAM and then refills it from the shadow array.

A RECALL also runs by itself after every reset, which stands for power-up. The shadow array is not touched by reset. While a transfer runs, the external port is locked out. The transfer engine moves one word per clock.

To keep the elaborated default small, the behavioural arrays hold 2^MW words (MW defaults to 10). The address port is AW bits wide (default 15), and the sequence comparison uses the full port width. A word is selected by the low MW address bits only.

Top module: `nvsram_ctrl`

## Requirements
- R1: With ce_n=0 and we_n=0 on a clock edge, din is written to the word at addr[MW-1:0]. With ce_n=0, we_n=1 and oe_n=0 on an edge while not busy, dout holds that word and dq_oe is 1 after the edge. Otherwise dq_oe is 0 after the edge.
- R2: Six reads, to 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0, start a STORE on the edge of the last read. Afterwards the shadow array holds the SRAM contents present at that edge.
- R3: The same first five reads followed by a read to 0x0C63 start a RECALL. When it finishes, the SRAM equals the shadow array.
- R4: A write anywhere in the sequence, or a read to any address other than the expected next one, aborts the sequence. An aborting read to 0x0E38 counts as a new first step.
- R5: Clock edges with ce_n=1 between steps neither advance nor abort the sequence.
- R6: busy is high for exactly 2^MW cycles for a STORE and 2*2^MW cycles for a RECALL, starting after the edge that starts the transfer.
- R7: While busy, dq_oe is 0, writes are ignored, and reads neither return data nor advance the sequence. The sequence restarts from its first step once busy falls.
- R8: After reset is released, busy stays high for a full RECALL. The SRAM then equals the shadow array as it stood before reset.
- R9: RECALL never changes the shadow array. Repeated RECALLs restore the same contents.
- R10: Each STORE started increments a wear count that saturates at ENDURANCE. wear_out is 1 exactly when the count equals ENDURANCE. Reset clears the count.
- R11: Sequence addresses must match on all AW bits. Data accesses alias on the low MW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; release acts as power-up and triggers a RECALL |
| addr | input | AW | Word address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, meaningful when dq_oe is 1 |
| dq_oe | output | 1 | Data output drive enable; 0 means the bus is released |
| busy | output | 1 | A STORE or RECALL is in progress |
| wear_out | output | 1 | STORE count has reached ENDURANCE |

## Verification
The embedded assertions watch properties that hold on every cycle:
- the port stays released in the cycle after any busy cycle;
- dq_oe only follows a qualifying read;
- every busy window has exactly the length its transfer kind requires;
- a transfer begins only on a read that completes the sequence;
- the wear count never exceeds its limit.

Whether data actually survives a STORE, a RECALL and a reset, and whether aborted or shadowed sequences fail to arm, can only be shown by the bench's scenarios. The bench compares the outputs on every clock against its behavioural model.

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int AW        = 15,
  parameter int MW        = 10,
  parameter int ENDURANCE = 4,
  parameter int CW        = $clog2(ENDURANCE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dq_oe,
  output logic          busy,
  output logic          wear_out
);
  localparam int DEPTH = 1 << MW;
  localparam logic [AW-1:0] KEY0 = AW'(16'h0E38);
  localparam logic [AW-1:0] KEY_STORE  = AW'(16'h0FC0);
  localparam logic [AW-1:0] KEY_RECALL = AW'(16'h0C63);

  logic [7:0] sram [DEPTH];
  logic [7:0] nv   [DEPTH];
  logic [MW-1:0] cnt;
  logic          refill, is_store;
  logic [2:0]    step, step_n;
  logic [CW-1:0] wear;

  function automatic logic [AW-1:0] key_at(input logic [2:0] i);
    case (i)
      3'd0:    key_at = AW'(16'h0E38);
      3'd1:    key_at = AW'(16'h31C7);
      3'd2:    key_at = AW'(16'h03E0);
      3'd3:    key_at = AW'(16'h3C1F);
      default: key_at = AW'(16'h303F);
    endcase
  endfunction

  wire          rd    = !ce_n && we_n;
  wire          wr    = !ce_n && !we_n;
  wire [MW-1:0] wa    = addr[MW-1:0];
  wire          arm   = rd && !busy && step == 3'd5;
  wire          go_st = arm && addr == KEY_STORE;
  wire          go_rc = arm && addr == KEY_RECALL;

  assign wear_out = wear == CW'(ENDURANCE);

  always_comb begin
    step_n = step;
    if (busy || wr)
      step_n = 3'd0;
    else if (rd) begin
      if (step < 3'd5 && addr == key_at(step)) step_n = step + 3'd1;
      else if (addr == KEY0)                   step_n = 3'd1;
      else                                     step_n = 3'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (busy) begin
      if (is_store)    nv[cnt]   <= sram[cnt];
      else if (refill) sram[cnt] <= nv[cnt];
      else             sram[cnt] <= 8'h00;
    end else if (wr)
      sram[wa] <= din;
    if (rd && !oe_n && !busy) dout <= sram[wa];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b1;
      is_store <= 1'b0;
      refill   <= 1'b0;
      cnt      <= '0;
      step     <= '0;
      dq_oe    <= 1'b0;
      wear     <= '0;
    end else begin
      dq_oe <= rd && !oe_n && !busy;
      step  <= step_n;
      if (busy) begin
        cnt <= cnt + 1'b1;
        if (&cnt) begin
          if (!is_store && !refill) refill <= 1'b1;
          else                      busy   <= 1'b0;
        end
      end else if (go_st || go_rc) begin
        busy     <= 1'b1;
        is_store <= go_st;
        refill   <= 1'b0;
        cnt      <= '0;
        if (go_st && !wear_out) wear <= wear + 1'b1;
      end
    end
  end

  logic [MW+1:0] busy_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_len <= '0;
    else        busy_len <= busy ? busy_len + 1'b1 : '0;

  assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dq_oe);
  assert_drive_after_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!ce_n && we_n && !oe_n));
  assert_window_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == (is_store ? (MW+2)'(DEPTH) : (MW+2)'(2*DEPTH)));
  assert_armed_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(rd && step == 3'd5));
  assert_wear_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wear <= CW'(ENDURANCE));
endmodule

// File: tb/sim_nvsram_ctrl.sv
module sim_nvsram_ctrl;
  localparam int DEPTH = 1024;
  localparam int ENDUR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [14:0] addr = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dq_oe, busy, wear_out;

  always #2.5 clk = ~clk;

  nvsram_ctrl u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
                  .we_n(we_n), .din(din), .dout(dout), .dq_oe(dq_oe), .busy(busy),
                  .wear_out(wear_out));

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] msram [DEPTH];
  logic [7:0] mnv   [DEPTH];
  logic [7:0] mdout;
  bit mbusy, mstore, moe;
  int mrem, mstep, mwear;
  int keys [5] = '{'h0E38, 'h31C7, 'h03E0, 'h3C1F, 'h303F};

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 1; mstore = 0; mrem = 2*DEPTH; mstep = 0; moe = 0; mwear = 0;
    end else begin
      int a;
      bit rdq, wrq;
      a = int'(addr);
      rdq = !ce_n && we_n;
      wrq = !ce_n && !we_n;
      moe = rdq && !oe_n && !mbusy;
      if (moe) mdout = msram[a % DEPTH];
      if (mbusy) begin
        mstep = 0;
        mrem--;
        if (mrem == 0) begin
          mbusy = 0;
          if (!mstore) msram = mnv;
        end
      end else if (wrq) begin
        msram[a % DEPTH] = din;
        mstep = 0;
      end else if (rdq) begin
        if (mstep == 5 && (a == 'h0FC0 || a == 'h0C63)) begin
          mbusy = 1;
          mstore = (a == 'h0FC0);
          mrem = mstore ? DEPTH : 2*DEPTH;
          if (mstore) begin
            mnv = msram;
            if (mwear < ENDUR) mwear++;
          end
          mstep = 0;
        end else if (mstep < 5 && a == keys[mstep]) mstep++;
        else if (a == 'h0E38) mstep = 1;
        else mstep = 0;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R6 busy vs model", int'(busy), int'(mbusy));
    chk("R7 dq_oe vs model", int'(dq_oe), int'(moe));
    chk("R10 wear_out vs model", int'(wear_out), int'(mwear == ENDUR));
    if (moe && !$isunknown(mdout)) chk("R1 dout vs model", int'(dout), int'(mdout));
  end

  task automatic wr_word(input int a, input int d);
    @(negedge clk);
    addr = 15'(a); din = 8'(d); ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic rd_word(input int a, output int d, output int oe);
    @(negedge clk);
    addr = 15'(a); ce_n = 0; we_n = 1; oe_n = 0;
    @(negedge clk);
    d = int'(dout); oe = int'(dq_oe);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic key_seq(input int last, input int gap);
    int d, o;
    for (int i = 0; i < 5; i++) begin
      rd_word(keys[i], d, o);
      repeat (gap) @(negedge clk);
    end
    rd_word(last, d, o);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 10*DEPTH) begin n++; @(negedge clk); end
  endtask

  function automatic int pat(input int i, input int s);
    return (i * 7 + s) & 8'hFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d, o, n;
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk("R8 busy at power-up", int'(busy), 1);
    chk("R8 dq_oe at power-up", int'(dq_oe), 0);
    busy_len(n);
    chk("R8 power-up recall length", n, 2*DEPTH);

    for (int i = 0; i < DEPTH; i++) wr_word(i, pat(i, 3));
    rd_word(17, d, o);
    chk("R1 read back", d, pat(17, 3));
    chk("R1 drive on read", o, 1);
    wr_word('h400 | 5, 'hA5);
    rd_word(5, d, o);
    chk("R11 alias on low bits", d, 'hA5);
    wr_word(5, pat(5, 3));

    key_seq('h0FC0, 2);
    chk("R5 store armed despite idle gaps", int'(busy), 1);
    wr_word(9, 'h11);
    rd_word(9, d, o);
    chk("R7 no drive while busy", o, 0);
    busy_len(n);
    chk("R2 R6 store length", n, DEPTH - 4);
    rd_word(9, d, o);
    chk("R7 write ignored while busy", d, pat(9, 3));

    for (int i = 0; i < 8; i++) wr_word(i, 'hF0 + i);
    key_seq('h0C63, 0);
    chk("R3 recall armed", int'(busy), 1);
    busy_len(n);
    chk("R6 recall length", n, 2*DEPTH);
    rd_word(3, d, o);
    chk("R3 recall restores", d, pat(3, 3));

    wr_word(3, 'h77);
    key_seq('h0C63, 0);
    busy_len(n);
    rd_word(3, d, o);
    chk("R9 second recall same data", d, pat(3, 3));

    rd_word(keys[0], d, o); rd_word(keys[1], d, o); rd_word(keys[2], d, o);
    wr_word(40, 'h40);
    rd_word(keys[3], d, o); rd_word(keys[4], d, o); rd_word('h0FC0, d, o);
    chk("R4 write aborts", int'(busy), 0);
    rd_word(keys[0], d, o); rd_word(keys[1], d, o); rd_word('h0123, d, o);
    rd_word(keys[2], d, o); rd_word(keys[3], d, o); rd_word(keys[4], d, o);
    rd_word('h0FC0, d, o);
    chk("R4 wrong address aborts", int'(busy), 0);
    rd_word(keys[0], d, o); rd_word(keys[1], d, o);
    key_seq('h0C63, 0);
    chk("R4 restart on first key", int'(busy), 1);
    busy_len(n);
    rd_word(40, d, o);
    chk("R4 recall after restart", d, pat(40, 3));

    rd_word('h0238, d, o);
    for (int i = 1; i < 5; i++) rd_word(keys[i], d, o);
    rd_word('h0FC0, d, o);
    chk("R11 upper address bits matter", int'(busy), 0);

    key_seq('h0FC0, 0);
    rd_word(keys[0], d, o); rd_word(keys[1], d, o);
    busy_len(n);
    for (int i = 2; i < 5; i++) rd_word(keys[i], d, o);
    rd_word('h0C63, d, o);
    chk("R7 busy reads do not advance", int'(busy), 0);

    for (int i = 0; i < DEPTH; i++) wr_word(i, pat(i, 9));
    key_seq('h0FC0, 0);
    busy_len(n);
    wr_word(100, 0);
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    busy_len(n);
    chk("R8 reset recall length", n, 2*DEPTH);
    rd_word(100, d, o);
    chk("R8 data survives reset", d, pat(100, 9));
    chk("R10 wear cleared by reset", int'(wear_out), 0);

    for (int k = 1; k <= ENDUR + 1; k++) begin
      key_seq('h0FC0, 0);
      busy_len(n);
      chk("R10 wear flag", int'(wear_out), int'(k >= ENDUR));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule